// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block produces the sync and data-enable timing for a parallel RGB display panel that is clocked by a pixel clock. A horizontal counter steps once per pixel clock. A vertical counter steps once per finished line. Each counter is compared against a small set of configuration inputs: the period, the sync pulse width, the back-porch wait between the sync edge and the first active position, and the size of the active window. The vertical period, pulse width, wait and window are all measured in whole lines.

Each of hsync, vsync and data-enable has its own polarity bit. The forwarded pixel clock can be inverted. The data-enable pin can be disabled for panels that do not use it. A master run input holds all timing idle until it is set. The configuration inputs are captured only at frame boundaries, and also continuously while timing is idle, so a change made mid-frame never shortens or stretches a line or frame.

For the pixel source, the block gives a request strobe together with the pixel and line coordinates of the pixel that will be shown on the next clock. It also gives a frame-start pulse that downstream logic can use.

Top module: `rgb_panel_timing`

## Requirements
- R1: While `sync_on` is low (and during reset) the counters sit at position 0, hsync, vsync and data-enable rest at their inactive level (the opposite of their polarity bit), and `pix_req`, `pix_x`, `pix_y` and `frame_start` are 0.
- R2: A line lasts `h_period` pixel clocks. hsync is active during the first `h_pulse` clocks of every line. A value of 0 gives no hsync pulse.
- R3: A frame lasts `v_period` whole lines. vsync is active for every clock of its first `v_pulse` lines. A value of 0 gives no vsync pulse.
- R4: Polarity bit 1 makes hsync, vsync or data-enable active high, and 0 makes it active low. `pix_clk_o` equals `clk` when `pclk_pol` is 0 and its inverse when `pclk_pol` is 1.
- R5: Data-enable is active exactly when the horizontal position lies in [`h_wait`, `h_wait`+`h_active`) and the line lies in [`v_wait`, `v_wait`+`v_active`), and only if `de_present` is 1. Otherwise it is held inactive.
- R6: `pix_req` is high one clock before each active data-enable position, whether or not `de_present` is set. With it come `pix_x` = position − `h_wait` and `pix_y` = line − `v_wait`, and both are 0 when `pix_req` is low.
- R7: Timing inputs that change while running take effect only from the next frame. The frame in progress keeps its old line length, pulse widths and window.
- R8: `frame_start` is high for one clock at position 0 of every frame, in the same clock as the vsync leading edge.
- R9: After `sync_on` rises, outputs for position 0 appear in the clock after it is first sampled high. This holds even if the previous run was stopped mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_on | input | 1 | Master run: timing outputs toggle only while high |
| de_present | input | 1 | Data-enable pin in use |
| hsync_pol | input | 1 | hsync active level |
| vsync_pol | input | 1 | vsync active level |
| de_pol | input | 1 | Data-enable active level |
| pclk_pol | input | 1 | Invert forwarded pixel clock |
| h_period | input | HW | Line length in pixel clocks |
| h_pulse | input | HW | hsync width in pixel clocks |
| h_wait | input | HW | Clocks from line start to first active pixel |
| h_active | input | HW | Active pixels per line |
| v_period | input | VW | Frame length in lines |
| v_pulse | input | VW | vsync width in lines |
| v_wait | input | VW | Lines from frame start to first active line |
| v_active | input | VW | Active lines per frame |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data-enable pin |
| pix_clk_o | output | 1 | Forwarded pixel clock |
| pix_req | output | 1 | Pixel request, one clock ahead of data-enable |
| frame_start | output | 1 | One-clock pulse at start of each frame |
| pix_x | output | HW | Column of the requested pixel |
| pix_y | output | VW | Row of the requested pixel |

## Verification
The hardest case to reach from the ports is a timing change that lands in the middle of a frame. Here the outputs must keep the old geometry until the frame wraps, and then switch at once without a runt line. The stimulus starts a run, waits until it is partway through the first frame, and then drives a whole new set of periods, pulses and windows. A reference model in the bench follows the pixel position and swaps its own copy of the configuration only at a frame boundary. Each vector run also ends mid-frame before the next run starts, so the restart from position 0 is covered after an interrupted frame.

// File: rtl/rgbt_pkg.sv
package rgbt_pkg;
   // index of each polarity-controlled output pin
   localparam int OUT_HS  = 0;
   localparam int OUT_VS  = 1;
   localparam int OUT_DE  = 2;
   localparam int NUM_OUT = 3;

   // default counter widths
   localparam int DEF_HW = 12;
   localparam int DEF_VW = 11;

   // pin level for an internal active flag under a polarity bit
   function automatic logic pin_level(input logic act, input logic pol);
      return pol ? act : ~act;
   endfunction
endpackage

// File: rtl/rgbt_axis_shadow.sv
module rgbt_axis_shadow #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] period_i,
   input  logic [W-1:0] pulse_i,
   input  logic [W-1:0] wait_i,
   input  logic [W-1:0] active_i,
   output logic [W-1:0] period_q,
   output logic [W-1:0] pulse_q,
   output logic [W-1:0] wait_q,
   output logic [W-1:0] active_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         pulse_q  <= '0;
         wait_q   <= '0;
         active_q <= '0;
      end else if (load) begin
         period_q <= period_i;
         pulse_q  <= pulse_i;
         wait_q   <= wait_i;
         active_q <= active_i;
      end
   end
endmodule

// File: rtl/rgbt_axis_ctr.sv
module rgbt_axis_ctr #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         adv,
   input  logic [W-1:0] period,
   output logic [W-1:0] cnt,
   output logic         last
);
   // period 0 or 1 both wrap every step
   assign last = ({1'b0, cnt} + {{W{1'b0}}, 1'b1}) >= {1'b0, period};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (adv)    cnt <= last ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/rgbt_axis_win.sv
module rgbt_axis_win #(
   parameter int W = 12
) (
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] pulse,
   input  logic [W-1:0] wait_c,
   input  logic [W-1:0] active,
   output logic         sync_act,
   output logic         in_win,
   output logic [W-1:0] offset
);
   logic [W:0] win_end;

   assign win_end  = {1'b0, wait_c} + {1'b0, active};
   assign sync_act = cnt < pulse;
   assign in_win   = (cnt >= wait_c) && ({1'b0, cnt} < win_end);
   assign offset   = in_win ? (cnt - wait_c) : '0;
endmodule

// File: rtl/rgbt_pol_stage.sv
module rgbt_pol_stage #(
   parameter int N = 3
) (
   input  logic [N-1:0] act,
   input  logic [N-1:0] pol,
   output logic [N-1:0] pin
);
   for (genvar i = 0; i < N; i++) begin : g_pin
      assign pin[i] = rgbt_pkg::pin_level(act[i], pol[i]);
   end
endmodule

// File: rtl/rgb_panel_timing.sv
module rgb_panel_timing
   import rgbt_pkg::*;
#(
   parameter int HW = DEF_HW,
   parameter int VW = DEF_VW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_on,
   input  logic          de_present,
   input  logic          hsync_pol,
   input  logic          vsync_pol,
   input  logic          de_pol,
   input  logic          pclk_pol,
   input  logic [HW-1:0] h_period,
   input  logic [HW-1:0] h_pulse,
   input  logic [HW-1:0] h_wait,
   input  logic [HW-1:0] h_active,
   input  logic [VW-1:0] v_period,
   input  logic [VW-1:0] v_pulse,
   input  logic [VW-1:0] v_wait,
   input  logic [VW-1:0] v_active,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          de_o,
   output logic          pix_clk_o,
   output logic          pix_req,
   output logic          frame_start,
   output logic [HW-1:0] pix_x,
   output logic [VW-1:0] pix_y
);
   // elaboration-time parameter checks
   if (HW < 2 || HW > 16) begin : g_bad_hw
      $error("rgb_panel_timing: HW must lie in 2..16");
   end
   if (VW < 2 || VW > 16) begin : g_bad_vw
      $error("rgb_panel_timing: VW must lie in 2..16");
   end

   logic [HW-1:0] sh_h_period, sh_h_pulse, sh_h_wait, sh_h_active;
   logic [VW-1:0] sh_v_period, sh_v_pulse, sh_v_wait, sh_v_active;
   logic [HW-1:0] h_cnt, h_off;
   logic [VW-1:0] v_cnt, v_off;
   logic          h_last, v_last;
   logic          h_sync, v_sync, h_in, v_in;
   logic          shadow_load, win;
   logic [NUM_OUT-1:0] act_q, pol_vec, pin_vec;
   logic          fs_q;

   // capture at frame wrap, or freely while idle
   assign shadow_load = !sync_on || (h_last && v_last);

   rgbt_axis_shadow #(.W(HW)) u_h_shadow (
      .clk(clk), .rst_n(rst_n), .load(shadow_load),
      .period_i(h_period), .pulse_i(h_pulse), .wait_i(h_wait), .active_i(h_active),
      .period_q(sh_h_period), .pulse_q(sh_h_pulse), .wait_q(sh_h_wait), .active_q(sh_h_active)
   );

   rgbt_axis_shadow #(.W(VW)) u_v_shadow (
      .clk(clk), .rst_n(rst_n), .load(shadow_load),
      .period_i(v_period), .pulse_i(v_pulse), .wait_i(v_wait), .active_i(v_active),
      .period_q(sh_v_period), .pulse_q(sh_v_pulse), .wait_q(sh_v_wait), .active_q(sh_v_active)
   );

   rgbt_axis_ctr #(.W(HW)) u_h_ctr (
      .clk(clk), .rst_n(rst_n), .run(sync_on), .adv(1'b1),
      .period(sh_h_period), .cnt(h_cnt), .last(h_last)
   );

   // vertical axis steps in whole lines
   rgbt_axis_ctr #(.W(VW)) u_v_ctr (
      .clk(clk), .rst_n(rst_n), .run(sync_on), .adv(h_last),
      .period(sh_v_period), .cnt(v_cnt), .last(v_last)
   );

   rgbt_axis_win #(.W(HW)) u_h_win (
      .cnt(h_cnt), .pulse(sh_h_pulse), .wait_c(sh_h_wait), .active(sh_h_active),
      .sync_act(h_sync), .in_win(h_in), .offset(h_off)
   );

   rgbt_axis_win #(.W(VW)) u_v_win (
      .cnt(v_cnt), .pulse(sh_v_pulse), .wait_c(sh_v_wait), .active(sh_v_active),
      .sync_act(v_sync), .in_win(v_in), .offset(v_off)
   );

   assign win     = h_in && v_in;
   assign pix_req = sync_on && win;
   assign pix_x   = pix_req ? h_off : '0;
   assign pix_y   = pix_req ? v_off : '0;

   // output register: pins show the counter position of the previous clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         fs_q  <= 1'b0;
      end else begin
         act_q[OUT_HS] <= sync_on && h_sync;
         act_q[OUT_VS] <= sync_on && v_sync;
         act_q[OUT_DE] <= sync_on && win && de_present;
         fs_q          <= sync_on && (h_cnt == '0) && (v_cnt == '0);
      end
   end

   always_comb begin
      pol_vec         = '0;
      pol_vec[OUT_HS] = hsync_pol;
      pol_vec[OUT_VS] = vsync_pol;
      pol_vec[OUT_DE] = de_pol;
   end

   rgbt_pol_stage #(.N(NUM_OUT)) u_pol (
      .act(act_q), .pol(pol_vec), .pin(pin_vec)
   );

   assign hsync_o     = pin_vec[OUT_HS];
   assign vsync_o     = pin_vec[OUT_VS];
   assign de_o        = pin_vec[OUT_DE];
   assign frame_start = fs_q;
   assign pix_clk_o   = clk ^ pclk_pol;
endmodule

// File: rtl/rgb_panel_timing_chk.sv
module rgb_panel_timing_chk #(
   parameter int HW = 12,
   parameter int VW = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sync_on,
   input logic          de_present,
   input logic          hsync_pol,
   input logic          vsync_pol,
   input logic          de_pol,
   input logic          hsync_o,
   input logic          vsync_o,
   input logic          de_o,
   input logic          pix_req,
   input logic          frame_start,
   input logic [HW-1:0] pix_x,
   input logic [VW-1:0] pix_y,
   input logic [HW-1:0] sh_h_active,
   input logic [VW-1:0] sh_v_pulse
);
   p_idle_hsync_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_on |=> (hsync_o == !hsync_pol));

   p_idle_vsync_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_on |=> (vsync_o == !vsync_pol));

   p_idle_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_on |-> (!pix_req && pix_x == '0 && pix_y == '0));

   p_de_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !de_present |=> (de_o == !de_pol));

   p_req_leads_de_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && de_present) |=> (de_o == de_pol));

   p_x_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pix_req |-> (pix_x < sh_h_active));

   p_fs_on_vsync_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && $past(sh_v_pulse) != '0) |-> (vsync_o == vsync_pol));
endmodule

bind rgb_panel_timing rgb_panel_timing_chk #(.HW(HW), .VW(VW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sync_on(sync_on), .de_present(de_present),
   .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .de_pol(de_pol),
   .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
   .pix_req(pix_req), .frame_start(frame_start), .pix_x(pix_x), .pix_y(pix_y),
   .sh_h_active(sh_h_active), .sh_v_pulse(sh_v_pulse)
);

// File: tb/rgb_panel_timing_test.sv
module rgb_panel_timing_test;
   localparam int HW = 12;
   localparam int VW = 11;

   // pol field: [3]=vsync [2]=hsync [1]=de [0]=pclk
   typedef struct packed {
      logic [7:0] hp, hpw, hwt, ha;
      logic [7:0] vp, vpw, vwt, va;
      logic [3:0] pol;
      logic       dep;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{8'd12, 8'd2, 8'd3, 8'd6,  8'd7, 8'd1, 8'd2, 8'd3, 4'b1111, 1'b1},
      '{8'd9,  8'd3, 8'd2, 8'd5,  8'd6, 8'd2, 8'd1, 8'd4, 4'b0000, 1'b1},
      '{8'd8,  8'd1, 8'd1, 8'd7,  8'd5, 8'd1, 8'd1, 8'd4, 4'b1010, 1'b0},
      '{8'd10, 8'd0, 8'd0, 8'd10, 8'd4, 8'd0, 8'd0, 8'd4, 4'b0101, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_on = 1'b0, de_present = 1'b0;
   logic hsync_pol = 1'b0, vsync_pol = 1'b0, de_pol = 1'b0, pclk_pol = 1'b0;
   logic [HW-1:0] h_period = '0, h_pulse = '0, h_wait = '0, h_active = '0;
   logic [VW-1:0] v_period = '0, v_pulse = '0, v_wait = '0, v_active = '0;
   logic hsync_o, vsync_o, de_o, pix_clk_o, pix_req, frame_start;
   logic [HW-1:0] pix_x;
   logic [VW-1:0] pix_y;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   vec_t drv, mc;
   int mh, mv;
   string phase = "";

   always #5 clk = ~clk;

   rgb_panel_timing #(.HW(HW), .VW(VW)) uut (.*);

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s%s actual=%0d expected=%0d at %0t", tag, phase, act, exp, $time);
      end
   endtask

   task automatic apply(input vec_t v);
      drv = v;
      h_period = {4'b0, v.hp};  h_pulse = {4'b0, v.hpw};
      h_wait   = {4'b0, v.hwt}; h_active = {4'b0, v.ha};
      v_period = {3'b0, v.vp};  v_pulse = {3'b0, v.vpw};
      v_wait   = {3'b0, v.vwt}; v_active = {3'b0, v.va};
      vsync_pol = v.pol[3]; hsync_pol = v.pol[2]; de_pol = v.pol[1]; pclk_pol = v.pol[0];
      de_present = v.dep;
   endtask

   function automatic bit in_win(input vec_t c, input int h, input int v);
      return (h >= c.hwt) && (h < c.hwt + c.ha) && (v >= c.vwt) && (v < c.vwt + c.va);
   endfunction

   function automatic logic lvl(input bit act, input logic pol);
      return pol ? logic'(act) : logic'(!act);
   endfunction

   // pins at rest, checked after a clock with sync_on low
   task automatic check_idle(input string tag);
      check(hsync_o == !drv.pol[2], tag, hsync_o, !drv.pol[2]);
      check(vsync_o == !drv.pol[3], tag, vsync_o, !drv.pol[3]);
      check(de_o == !drv.pol[1], tag, de_o, !drv.pol[1]);
      check(pix_req == 1'b0 && pix_x == '0 && pix_y == '0, tag, pix_req, 0);
      check(frame_start == 1'b0, tag, frame_start, 0);
   endtask

   task automatic run_cycles(input int n, input bit first_is_start);
      bit e_hs, e_vs, e_de, e_fs, e_req;
      int e_x, e_y;
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         e_hs = mh < int'(mc.hpw);
         e_vs = mv < int'(mc.vpw);
         e_de = in_win(mc, mh, mv) && drv.dep;
         e_fs = (mh == 0) && (mv == 0);
         // advance the model; geometry reloads only at frame wrap
         if (mh + 1 >= int'(mc.hp)) begin
            mh = 0;
            if (mv + 1 >= int'(mc.vp)) begin
               mv = 0;
               mc = drv;
            end else mv++;
         end else mh++;
         e_req = in_win(mc, mh, mv);
         e_x = e_req ? mh - int'(mc.hwt) : 0;
         e_y = e_req ? mv - int'(mc.vwt) : 0;
         @(negedge clk);
         check(hsync_o == lvl(e_hs, drv.pol[2]), "R2 hsync", hsync_o, lvl(e_hs, drv.pol[2]));
         check(vsync_o == lvl(e_vs, drv.pol[3]), "R3 vsync", vsync_o, lvl(e_vs, drv.pol[3]));
         check(de_o == lvl(e_de, drv.pol[1]), "R5 de", de_o, lvl(e_de, drv.pol[1]));
         check(pix_req == e_req, "R6 req", pix_req, e_req);
         check(int'(pix_x) == e_x, "R6 x", pix_x, e_x);
         check(int'(pix_y) == e_y, "R6 y", pix_y, e_y);
         check(frame_start == e_fs, "R8 fs", frame_start, e_fs);
         check(pix_clk_o == drv.pol[0], "R4 pclk", pix_clk_o, drv.pol[0]);
         if (k == 0 && first_is_start)
            check(frame_start == 1'b1, "R9 restart", frame_start, 1);
      end
   endtask

   task automatic enable_run();
      @(negedge clk);
      sync_on = 1'b1;
      mh = 0; mv = 0; mc = drv;
   endtask

   task automatic stop_run();
      @(negedge clk);
      sync_on = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk);
         @(negedge clk);
         check_idle("R1 stopped");
      end
   endtask

   initial begin
      #(10 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      apply(VECS[0]);
      // reset state, R1
      repeat (3) @(negedge clk);
      check_idle("R1 reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle("R1 idle");

      // vector table; each run ends mid-frame (R9 restart follows)
      for (int i = 0; i < 4; i++) begin
         apply(VECS[i]);
         enable_run();
         run_cycles(2 * int'(VECS[i].hp) * int'(VECS[i].vp) + 3, 1'b1);
         stop_run();
      end

      // R4: flip polarities while idle, pins follow
      apply(VECS[1]);
      @(negedge clk);
      check_idle("R4 pol low");
      check(pix_clk_o == 1'b0, "R4 pclk", pix_clk_o, 0);
      apply(VECS[0]);
      @(negedge clk);
      check_idle("R4 pol high");
      check(pix_clk_o == 1'b1, "R4 pclk", pix_clk_o, 1);

      // R7: new geometry driven mid-frame takes effect at next frame only
      apply(VECS[0]);
      enable_run();
      run_cycles(20, 1'b1);
      phase = " R7";
      apply(VECS[1]);
      run_cycles(2 * 84 + 2 * 54, 1'b0);
      phase = "";
      stop_run();

      // R5: de_present dropped while running keeps de inactive
      apply(VECS[1]);
      enable_run();
      run_cycles(10, 1'b1);
      de_present = 1'b0; drv.dep = 1'b0;
      run_cycles(60, 1'b0);
      stop_run();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule